// File: doc/BRIEF.md
# Display Configuration Command Parser

This block sits on the byte stream that feeds the framebuffer controller and decodes the display configuration command. Bytes arrive with a valid/ready handshake. A command starts with the code byte 0x01. A flags byte follows. When graphics output is enabled, these come next in order: a resolution code, a palette flag, an optional 768-byte palette, an optional list of palette animation block locations with a speed byte, and a list of 4-byte viewport descriptors. Sections that are not present take no bytes.

The parser keeps the display control state in registers: local video, graphics enable, two address-doubling bits and the resolution, decoded to a width and a line count. It streams palette and animation bytes out through write ports, one byte per accepted input. It stores up to three viewport descriptors in consecutive slots. When a command ends, it holds off input for one cycle and pulses a completion strobe. If a palette arrived, it pulses a palette copy request in that same cycle.

Top module: `fbc_parser`

## Requirements
- R1: After reset, in_ready is 1, cmd_done and pal_copy are 0, every control output and vp_count are 0, anim_count and anim_speed are 0, and the decoded resolution is 384 by 120.
- R2: While no command is open, any byte other than 0x01 is accepted and discarded: no register changes and no strobe fires, and the next 0x01 starts a command normally.
- R3: The byte after 0x01 is the flags byte. Bit 0 sets local_video_en, bit 1 sets dbl_h, bit 2 sets gfx_en and bit 3 sets dbl_v. The registers take the new values on the clock edge that accepts the byte.
- R4: If flags bit 2 is 0, the command ends right after the flags byte. No further byte belongs to it, and resolution, animation and viewport state keep their old values.
- R5: With graphics enabled, the next byte's low two bits set res_mode. Codes 0, 1, 2 and 3 decode to 384x120, 384x240, 768x240 and 768x480 on res_width and res_height.
- R6: A palette flag byte equal to 1 makes the next 768 bytes palette data. Each is presented with pal_we high, pal_addr running 0 to 767 and pal_data equal to the input byte, in the same cycle it is accepted. Any other flag value means no palette bytes and no pal_we.
- R7: The next byte N is stored in anim_count. If N is nonzero, N location bytes follow, each with anim_we high and anim_idx running 0 to N-1, and then one byte that is stored in anim_speed. If N is 0, neither follows and anim_speed keeps its value.
- R8: The next byte C is the viewport count, followed by 4*C bytes. Descriptor k goes to slot k, and its byte b goes to vp_desc bits [32k+8b +: 8]. vp_count becomes the smaller of C and 3. Slots that are not written keep their contents.
- R9: For every slot, vp_lines equals twice the descriptor's fourth byte (byte 3). For example, 0xF0 gives 480.
- R10: Descriptors after the third are accepted and discarded without touching any slot, and the byte following them is taken as the start of a new command.
- R11: The clock edge that accepts a command's last byte is followed by exactly one cycle with cmd_done high and in_ready low. After that, in_ready returns to 1.
- R12: pal_copy pulses together with cmd_done only when that command loaded a palette (R6). It stays 0 for commands without a palette and for commands ended by a clear graphics flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser can accept a byte |
| local_video_en | output | 1 | Local video enable |
| gfx_en | output | 1 | Graphics output enable |
| dbl_h | output | 1 | Address doubling, flags bit 1 |
| dbl_v | output | 1 | Address doubling, flags bit 3 |
| res_mode | output | 2 | Resolution code |
| res_width | output | 10 | Decoded active width in pixels |
| res_height | output | 9 | Decoded active height in lines |
| pal_we | output | 1 | Palette byte write strobe |
| pal_addr | output | $clog2(PAL_BYTES) | Palette byte address |
| pal_data | output | 8 | Palette byte |
| anim_count | output | 8 | Number of animation blocks |
| anim_we | output | 1 | Animation location write strobe |
| anim_idx | output | 8 | Animation location index |
| anim_loc | output | 8 | Animation location byte |
| anim_speed | output | 8 | Animation speed byte |
| vp_count | output | $clog2(NUM_VP+1) | Stored viewport count |
| vp_desc | output | 32*NUM_VP | Viewport descriptor slots |
| vp_lines | output | 9*NUM_VP | Lines per slot, twice byte 3 |
| cmd_done | output | 1 | Command finished, one-cycle pulse |
| pal_copy | output | 1 | Palette copy request, one-cycle pulse |

## Verification
Every flags value from 0 to 15 is sent as a command, so each flag bit is seen both set and clear. Values with bit 2 clear must end after two bytes, and values with bit 2 set pass through all four resolution codes. Across these commands, animation counts of 0, 1 and 2, viewport counts of 0 to 4 and palette flags of 0, 1 and 2 are mixed. This separates sections that are skipped from sections that are shifted, and it shows whether a flag value of 2 is wrongly treated as a palette. A seven-descriptor command followed by a one-descriptor command confirms that surplus descriptors are dropped and the stream stays aligned. Stray bytes sent between commands, including 0x04, which would read as a flags byte, show that idle bytes are discarded.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam logic [7:0] CMD_CODE = 8'h01;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FLAGS,
        S_RES,
        S_PALF,
        S_PAL,
        S_ANIMN,
        S_ANIML,
        S_SPEED,
        S_VPN,
        S_VPD,
        S_DONE
    } fbc_state_e;

    typedef struct packed {
        logic [3:0] unused;
        logic       dbl_v;
        logic       gfx;
        logic       dbl_h;
        logic       local_vid;
    } fbc_flags_t;

    function automatic logic [9:0] res_to_width(input logic [1:0] code);
        return code[1] ? 10'd768 : 10'd384;
    endfunction

    function automatic logic [8:0] res_to_height(input logic [1:0] code);
        case (code)
            2'd0:    return 9'd120;
            2'd3:    return 9'd480;
            default: return 9'd240;
        endcase
    endfunction

endpackage

// File: rtl/fbc_fsm.sv
module fbc_fsm
    import fbc_pkg::*;
#(
    parameter int PAL_BYTES = 768,
    parameter int IDX_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             accept,
    output fbc_state_e       st,
    output logic [IDX_W-1:0] idx,
    output logic             pal_loaded
);

    localparam logic [IDX_W-1:0] PAL_LAST = IDX_W'(PAL_BYTES - 1);

    logic [7:0] anim_n;
    logic [7:0] vp_n;
    fbc_flags_t fl;

    assign fl       = fbc_flags_t'(in_data);
    assign in_ready = (st != S_DONE);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            idx        <= '0;
            anim_n     <= '0;
            vp_n       <= '0;
            pal_loaded <= 1'b0;
        end else if (st == S_DONE) begin
            st <= S_IDLE;
        end else if (accept) begin
            unique case (st)
                S_IDLE: begin
                    if (in_data == CMD_CODE) begin
                        st         <= S_FLAGS;
                        pal_loaded <= 1'b0;
                    end
                end
                S_FLAGS: st <= fl.gfx ? S_RES : S_DONE;
                S_RES:   st <= S_PALF;
                S_PALF: begin
                    idx <= '0;
                    if (in_data == 8'd1) begin
                        st         <= S_PAL;
                        pal_loaded <= 1'b1;
                    end else begin
                        st <= S_ANIMN;
                    end
                end
                S_PAL: begin
                    if (idx == PAL_LAST) st <= S_ANIMN;
                    else                 idx <= idx + 1'b1;
                end
                S_ANIMN: begin
                    anim_n <= in_data;
                    idx    <= '0;
                    st     <= (in_data == 8'd0) ? S_VPN : S_ANIML;
                end
                S_ANIML: begin
                    if (idx[7:0] == anim_n - 8'd1) st <= S_SPEED;
                    else                           idx <= idx + 1'b1;
                end
                S_SPEED: st <= S_VPN;
                S_VPN: begin
                    vp_n <= in_data;
                    idx  <= '0;
                    st   <= (in_data == 8'd0) ? S_DONE : S_VPD;
                end
                S_VPD: begin
                    if (idx[9:2] == vp_n - 8'd1 && idx[1:0] == 2'd3) st <= S_DONE;
                    else                                              idx <= idx + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2: stray bytes outside a command leave the parser idle
    p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && accept && in_data != CMD_CODE) |=> (st == S_IDLE));

    // R11: the finishing state lasts a single cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (st == S_DONE) |=> (st == S_IDLE && in_ready));

    // R4: a clear graphics flag closes the command immediately
    p_gfx_off_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_FLAGS && accept && !in_data[2]) |=> (st == S_DONE));

endmodule

// File: rtl/fbc_vp_store.sv
module fbc_vp_store #(
    parameter int NUM_VP = 3,
    parameter int CW     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_we,
    input  logic [7:0]           cnt_in,
    input  logic                 wr_en,
    input  logic [7:0]           wr_slot,
    input  logic [1:0]           wr_byte,
    input  logic [7:0]           wr_data,
    output logic [CW-1:0]        vp_count,
    output logic [32*NUM_VP-1:0] vp_desc,
    output logic [9*NUM_VP-1:0]  vp_lines
);

    always_ff @(posedge clk) begin
        if (rst)
            vp_count <= '0;
        else if (cnt_we)
            vp_count <= (cnt_in > 8'(NUM_VP)) ? CW'(NUM_VP) : cnt_in[CW-1:0];
    end

    for (genvar k = 0; k < NUM_VP; k++) begin : g_slot
        logic [31:0] desc;
        always_ff @(posedge clk) begin
            if (rst)
                desc <= '0;
            else if (wr_en && wr_slot == 8'(k))
                desc[8*wr_byte +: 8] <= wr_data;
        end
        assign vp_desc[32*k +: 32] = desc;
        assign vp_lines[9*k +: 9]  = {desc[31:24], 1'b0};
    end

    // R10: the stored count never exceeds the slot count
    p_vp_cap_r10: assert property (@(posedge clk) disable iff (rst)
        vp_count <= CW'(NUM_VP));

    // R10: a write aimed past the last slot changes no slot
    p_vp_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_slot >= 8'(NUM_VP)) |=> $stable(vp_desc));

endmodule

// File: rtl/fbc_parser.sv
module fbc_parser
    import fbc_pkg::*;
#(
    parameter  int PAL_BYTES = 768,
    parameter  int NUM_VP    = 3,
    localparam int PAW       = $clog2(PAL_BYTES),
    localparam int VPC_W     = $clog2(NUM_VP + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 local_video_en,
    output logic                 gfx_en,
    output logic                 dbl_h,
    output logic                 dbl_v,
    output logic [1:0]           res_mode,
    output logic [9:0]           res_width,
    output logic [8:0]           res_height,
    output logic                 pal_we,
    output logic [PAW-1:0]       pal_addr,
    output logic [7:0]           pal_data,
    output logic [7:0]           anim_count,
    output logic                 anim_we,
    output logic [7:0]           anim_idx,
    output logic [7:0]           anim_loc,
    output logic [7:0]           anim_speed,
    output logic [VPC_W-1:0]     vp_count,
    output logic [32*NUM_VP-1:0] vp_desc,
    output logic [9*NUM_VP-1:0]  vp_lines,
    output logic                 cmd_done,
    output logic                 pal_copy
);

    localparam int IDX_W = (PAW > 10) ? PAW : 10;

    fbc_state_e       st;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic             pal_loaded;
    fbc_flags_t       fl;

    fbc_fsm #(.PAL_BYTES(PAL_BYTES), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .accept     (accept),
        .st         (st),
        .idx        (idx),
        .pal_loaded (pal_loaded)
    );

    assign fl = fbc_flags_t'(in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            local_video_en <= 1'b0;
            gfx_en         <= 1'b0;
            dbl_h          <= 1'b0;
            dbl_v          <= 1'b0;
            res_mode       <= 2'd0;
            anim_count     <= 8'd0;
            anim_speed     <= 8'd0;
        end else if (accept) begin
            case (st)
                S_FLAGS: begin
                    local_video_en <= fl.local_vid;
                    gfx_en         <= fl.gfx;
                    dbl_h          <= fl.dbl_h;
                    dbl_v          <= fl.dbl_v;
                end
                S_RES:   res_mode   <= in_data[1:0];
                S_ANIMN: anim_count <= in_data;
                S_SPEED: anim_speed <= in_data;
                default: ;
            endcase
        end
    end

    assign res_width  = res_to_width(res_mode);
    assign res_height = res_to_height(res_mode);

    assign pal_we   = accept && (st == S_PAL);
    assign pal_addr = idx[PAW-1:0];
    assign pal_data = in_data;

    assign anim_we  = accept && (st == S_ANIML);
    assign anim_idx = idx[7:0];
    assign anim_loc = in_data;

    assign cmd_done = (st == S_DONE);
    assign pal_copy = cmd_done && pal_loaded;

    fbc_vp_store #(.NUM_VP(NUM_VP), .CW(VPC_W)) u_vp (
        .clk      (clk),
        .rst      (rst),
        .cnt_we   (accept && st == S_VPN),
        .cnt_in   (in_data),
        .wr_en    (accept && st == S_VPD),
        .wr_slot  (idx[9:2]),
        .wr_byte  (idx[1:0]),
        .wr_data  (in_data),
        .vp_count (vp_count),
        .vp_desc  (vp_desc),
        .vp_lines (vp_lines)
    );

    // R6: consecutive palette writes step the address by one
    p_pal_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (pal_we && $past(pal_we)) |-> (pal_addr == $past(pal_addr) + 1'b1));

    // R7: consecutive location writes step the index by one
    p_anim_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
        (anim_we && $past(anim_we)) |-> (anim_idx == $past(anim_idx) + 8'd1));

    // R12: a copy request only ever comes with completion
    p_copy_only_done_r12: assert property (@(posedge clk) disable iff (rst)
        pal_copy |-> cmd_done);

    // R11: input is held off while completion is signalled
    p_busy_on_done_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> !in_ready);

endmodule

// File: tb/fbc_parser_test.sv
`timescale 1ns/1ps
module fbc_parser_test;

    localparam int NVP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic in_ready, local_video_en, gfx_en, dbl_h, dbl_v;
    logic [1:0] res_mode;
    logic [9:0] res_width;
    logic [8:0] res_height;
    logic pal_we, anim_we, cmd_done, pal_copy;
    logic [9:0] pal_addr;
    logic [7:0] pal_data, anim_count, anim_idx, anim_loc, anim_speed;
    logic [1:0] vp_count;
    logic [32*NVP-1:0] vp_desc;
    logic [9*NVP-1:0] vp_lines;

    always #2.5 clk = ~clk;

    fbc_parser uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .local_video_en(local_video_en), .gfx_en(gfx_en), .dbl_h(dbl_h), .dbl_v(dbl_v),
        .res_mode(res_mode), .res_width(res_width), .res_height(res_height),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
        .anim_count(anim_count), .anim_we(anim_we), .anim_idx(anim_idx), .anim_loc(anim_loc),
        .anim_speed(anim_speed), .vp_count(vp_count), .vp_desc(vp_desc), .vp_lines(vp_lines),
        .cmd_done(cmd_done), .pal_copy(pal_copy)
    );

    int checks = 0;
    int errors = 0;
    int pal_wr, pal_bad, anim_wr, anim_bad, done_cnt;
    logic [7:0] evp [NVP][4];
    logic [7:0] e_speed = 8'd0;
    logic [1:0] e_res = 2'd0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) if (!rst && cmd_done) done_cnt++;

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        #1;
        if (pal_we) begin
            if (pal_addr != 10'(pal_wr) || pal_data != b) pal_bad++;
            pal_wr++;
        end
        if (anim_we) begin
            if (anim_idx != 8'(anim_wr) || anim_loc != b) anim_bad++;
            anim_wr++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] vbyte(input int k, input int b, input int seed);
        return 8'(k * 16 + b * 3 + seed * 5 + 1);
    endfunction

    task automatic cmd(input int f, input int pf, input int na, input int nvp, input int seed);
        int lim;
        pal_wr = 0; pal_bad = 0; anim_wr = 0; anim_bad = 0;
        send(8'h01);
        send(8'(f));
        if (f[2]) begin
            e_res = 2'(f);
            send(8'(f));
            send(8'(pf));
            if (pf == 1) for (int i = 0; i < 768; i++) send(8'(i * 7 + seed));
            send(8'(na));
            for (int i = 0; i < na; i++) send(8'(i + seed + 9));
            if (na > 0) begin
                e_speed = 8'(seed + 100);
                send(e_speed);
            end
            send(8'(nvp));
            for (int k = 0; k < nvp; k++)
                for (int b = 0; b < 4; b++) begin
                    send(vbyte(k, b, seed));
                    if (k < NVP) evp[k][b] = vbyte(k, b, seed);
                end
        end
        // completion cycle
        chk(cmd_done == 1'b1, "R11 done after last byte", cmd_done, 1);
        chk(in_ready == 1'b0, "R11 ready low on done", in_ready, 0);
        chk(pal_copy == (f[2] && pf == 1), "R12 pal_copy", pal_copy, (f[2] && pf == 1));
        chk({dbl_v, gfx_en, dbl_h, local_video_en} == 4'(f), "R3 flags", {dbl_v, gfx_en, dbl_h, local_video_en}, f & 15);
        chk(res_mode == e_res && res_width == (e_res[1] ? 10'd768 : 10'd384)
            && res_height == (e_res == 0 ? 9'd120 : e_res == 3 ? 9'd480 : 9'd240),
            f[2] ? "R5 resolution" : "R4 resolution kept", {res_mode, res_width, res_height}, e_res);
        if (f[2]) begin
            chk(pal_wr == (pf == 1 ? 768 : 0) && pal_bad == 0, "R6 palette writes", pal_wr, (pf == 1 ? 768 : 0));
            chk(anim_count == 8'(na) && anim_wr == na && anim_bad == 0, "R7 animation count/locs", anim_wr, na);
            chk(anim_speed == e_speed, "R7 animation speed", anim_speed, e_speed);
            lim = (nvp > NVP) ? NVP : nvp;
            chk(vp_count == 2'(lim), "R8 viewport count", vp_count, lim);
        end else begin
            chk(pal_wr == 0 && anim_wr == 0, "R4 no section bytes", pal_wr + anim_wr, 0);
            chk(anim_speed == e_speed, "R4 speed kept", anim_speed, e_speed);
        end
        for (int k = 0; k < NVP; k++) begin
            chk(vp_desc[32*k +: 32] == {evp[k][3], evp[k][2], evp[k][1], evp[k][0]},
                nvp > NVP ? "R10 slot contents" : "R8 slot contents",
                vp_desc[32*k +: 32], {evp[k][3], evp[k][2], evp[k][1], evp[k][0]});
            chk(vp_lines[9*k +: 9] == {evp[k][3], 1'b0}, "R9 lines", vp_lines[9*k +: 9], {evp[k][3], 1'b0});
        end
        @(posedge clk);
        #1;
        chk(cmd_done == 1'b0 && pal_copy == 1'b0 && in_ready == 1'b1, "R11 single pulse",
            {cmd_done, pal_copy, in_ready}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int dc;
        for (int k = 0; k < NVP; k++) for (int b = 0; b < 4; b++) evp[k][b] = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !cmd_done && !pal_copy, "R1 handshake reset", {in_ready, cmd_done, pal_copy}, 4);
        chk({local_video_en, gfx_en, dbl_h, dbl_v, res_mode} == 0 && vp_count == 0
            && anim_count == 0 && anim_speed == 0, "R1 registers reset", {local_video_en, gfx_en, res_mode}, 0);
        chk(res_width == 10'd384 && res_height == 9'd120, "R1 resolution reset", {res_width, res_height}, {10'd384, 9'd120});

        dc = done_cnt;
        send(8'h00); send(8'h04); send(8'hFF); send(8'h02);
        @(negedge clk);
        chk(done_cnt == dc && !gfx_en && !local_video_en && res_mode == 0, "R2 stray bytes ignored",
            done_cnt - dc, 0);

        for (int f = 0; f < 16; f++)
            cmd(f, (f == 5) ? 1 : (f == 12) ? 2 : 0, f % 3, f % 5, f);

        cmd(15, 1, 2, 7, 40);
        cmd(6, 0, 0, 1, 50);

        dc = done_cnt;
        send(8'h04);
        @(negedge clk);
        chk(done_cnt == dc && gfx_en, "R2 idle byte after command", done_cnt - dc, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule